// File: doc/BRIEF.md
# Dual-Reload Programmable Timer Channel

This block is one 32-bit timer/counter channel. A mode word, written in one cycle, picks the count direction, one-shot or repeating operation, the clock, gate and trigger sources, and how the output pin is driven. Two reload registers, A and B, hold the values the counter takes on a load. When alternate reload is enabled, the channel uses A or B depending on its output toggle flop. A repeating count whose toggle output drives the pin then gives a hardware PWM waveform. The high phase length comes from A and the low phase length comes from B.

The counting clock is either a one-cycle enable from a shared prescaler running on the core clock, or an edge of an external source. The external sources are the TxIN pin and the outputs of the two neighbouring channels. Each external source passes through a synchroniser and an edge detector. One-cycle command strobes start, stop, load, clear, set the toggle and clear the toggle. A trigger edge loads the counter and sets it running.

Top module: `timer_channel`

## Requirements
- R1: After reset the count is 0, the running flag and the toggle are 0, and the output pin is low, because the output-drive field resets to 10 (forced low). The whole mode word resets to 0x00020.
- R2: While running, the count moves by one on every enabled tick. The direction is mode bit 0 (1 up, 0 down). Terminal count occurs on a tick taken at 0 when counting down, or at all-ones when counting up. On that tick the count reloads instead of stepping, and the toggle inverts.
- R3: Mode bit 1 = 1 keeps the channel running after terminal count. Mode bit 1 = 0 clears the running flag at terminal count, after the reload.
- R4: With mode bit 2 = 0 every reload takes register A. With bit 2 = 1 a reload takes A when the toggle is 1 and B when it is 0. At terminal count the toggle value after inversion decides. For a load command or a trigger, the current toggle value decides.
- R5: With mode bit 3 = 1 the raw output is the toggle. With bit 3 = 0 the raw output is a one-cycle pulse, high in the cycle after the terminal-count edge.
- R6: Mode bits 5:4 drive the pin: 00 raw output, 01 inverted raw output, 10 forced low, 11 forced high.
- R7: Strobes act only while high. Clear forces the count to 0 and beats load, trigger and counting. Stop beats start and trigger. Toggle-clear beats toggle-set, and both beat terminal-count inversion. Load takes the reload register chosen per R4.
- R8: Clock source codes 0000, 0001, 0010 and 0011 (mode bits 17:14) count on every core-clock cycle, every 5th, every 50th or every 500th cycle.
- R9: For clock codes with bits 17:16 = 01 (TxIN), 10 (previous channel) or 11 (next channel), bits 15:14 = 01, 10 or 11 count rising, falling or both edges of that source. An input change is counted at the third core-clock edge after it. Codes 0100, 1000 and 1100 never count.
- R10: Gate source bits 12:11 choose constant high (00), TxIN (01), previous channel (10) or next channel (11). Bit 13 = 0 blocks counting while the gate is low; bit 13 = 1 blocks it while the gate is high.
- R11: Trigger source bits 7:6 (00 none, 01 TxIN, 10 previous, 11 next) and edge bits 9:8 (00 none, 01 rising, 10 falling, 11 both) select a trigger. A trigger loads the reload register and sets the running flag at the third core-clock edge after the input change.
- R12: With mode bit 10 = 0 a trigger is ignored while the channel runs. With bit 10 = 1 it reloads a running channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the mode word |
| mode_data | input | 18 | Mode word |
| loada_wr | input | 1 | Write strobe for reload register A |
| loadb_wr | input | 1 | Write strobe for reload register B |
| load_data | input | WIDTH | Data for reload register writes |
| cmd_start | input | 1 | Start strobe |
| cmd_stop | input | 1 | Stop strobe |
| cmd_load | input | 1 | Load-count strobe |
| cmd_reset | input | 1 | Clear-count strobe |
| cmd_tset | input | 1 | Toggle-set strobe |
| cmd_treset | input | 1 | Toggle-clear strobe |
| txin | input | 1 | External channel pin (clock, gate or trigger) |
| prev_out | input | 1 | Output of the previous channel |
| next_out | input | 1 | Output of the next channel |
| count | output | WIDTH | Live count |
| running | output | 1 | Running flag |
| toggle | output | 1 | Output toggle state |
| out_pin | output | 1 | Conditioned output pin |

## Verification
The hardest situation to reach from the ports is alternating reload across consecutive terminal counts. This needs a known toggle state at the moment of the first load and a repeating count, and only then does each phase take the other register. The stimulus first sets the toggle with its strobe, loads, and starts the channel. A cycle-by-cycle model in the bench then predicts count, toggle and pin over several PWM periods.

Retriggering a running channel is reached by pulsing the neighbour input while the count is mid-flight, once with retrigger off and once with it on. The gate and external clock paths are driven with inputs held long enough to cover the synchroniser latency.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  localparam int unsigned MODE_W = 18;
  localparam int unsigned NRATE  = 4;

  typedef enum logic [1:0] {
    OUT_DIRECT = 2'b00,
    OUT_INVERT = 2'b01,
    OUT_LOW    = 2'b10,
    OUT_HIGH   = 2'b11
  } out_ctl_e;

  typedef struct packed {
    logic [3:0] clk_src;     // 17:14
    logic       gate_pol;    // 13
    logic [1:0] gate_src;    // 12:11
    logic       retrig;      // 10
    logic [1:0] trig_edge;   // 9:8
    logic [1:0] trig_src;    // 7:6
    out_ctl_e   out_ctl;     // 5:4
    logic       out_tgl;     // 3
    logic       reload_alt;  // 2
    logic       rep_en;      // 1
    logic       count_up;    // 0
  } tmr_mode_t;

  localparam logic [MODE_W-1:0] MODE_RST = 18'h00020;

  // select rising, falling or both edges; 00 gives nothing
  function automatic logic edge_pick(input logic [1:0] sel, input logic r, input logic f);
    case (sel)
      2'b01:   return r;
      2'b10:   return f;
      2'b11:   return r | f;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int unsigned NSTAGE = 3,
  parameter int unsigned STAGE_DIV [NSTAGE] = '{5, 10, 10}
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NSTAGE:0] tick
);

  assign tick[0] = 1'b1;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    localparam int unsigned DW = $clog2(STAGE_DIV[s]);
    logic [DW-1:0] cnt_q, cnt_d;
    logic          wrap;

    assign wrap = tick[s] && (cnt_q == DW'(STAGE_DIV[s] - 1));

    always_comb begin
      cnt_d = wrap ? '0 : cnt_q + DW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (tick[s]) cnt_q <= cnt_d;
    end

    assign tick[s+1] = wrap;
  end

endmodule

// File: rtl/tmr_edge_sync.sv
`timescale 1ns/1ps
module tmr_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);

  logic [2:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign lvl  = sh_q[1];
  assign rise =  sh_q[1] & ~sh_q[2];
  assign fall = ~sh_q[1] &  sh_q[2];

endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core
  import tmr_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_mode_t        mode,
  input  logic [WIDTH-1:0] reg_a,
  input  logic [WIDTH-1:0] reg_b,
  input  logic             cnt_en,
  input  logic             trig_go,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             cmd_load,
  input  logic             cmd_reset,
  input  logic             cmd_tset,
  input  logic             cmd_treset,
  output logic [WIDTH-1:0] count,
  output logic             running,
  output logic             toggle,
  output logic             tc_pulse
);

  logic [WIDTH-1:0] count_q, count_d;
  logic             run_q, run_d;
  logic             tog_q, tog_d;
  logic             tcp_q, tcp_d;
  logic             at_end, tc, tog_after;
  logic [WIDTH-1:0] ld_now, ld_tc;

  always_comb begin
    at_end    = mode.count_up ? (count_q == '1) : (count_q == '0);
    tc        = run_q && cnt_en && at_end;
    tog_after = tog_q ^ tc;
    ld_now    = (mode.reload_alt && !tog_q)     ? reg_b : reg_a;
    ld_tc     = (mode.reload_alt && !tog_after) ? reg_b : reg_a;

    count_d = count_q;
    if (cmd_reset)                count_d = '0;
    else if (cmd_load || trig_go) count_d = ld_now;
    else if (tc)                  count_d = ld_tc;
    else if (run_q && cnt_en)     count_d = mode.count_up ? count_q + WIDTH'(1)
                                                          : count_q - WIDTH'(1);

    run_d = run_q;
    if (cmd_stop)                  run_d = 1'b0;
    else if (cmd_start || trig_go) run_d = 1'b1;
    else if (tc && !mode.rep_en)   run_d = 1'b0;

    tog_d = tog_after;
    if (cmd_treset)    tog_d = 1'b0;
    else if (cmd_tset) tog_d = 1'b1;

    tcp_d = tc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      run_q   <= 1'b0;
      tog_q   <= 1'b0;
      tcp_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      run_q   <= run_d;
      tog_q   <= tog_d;
      tcp_q   <= tcp_d;
    end
  end

  assign count    = count_q;
  assign running  = run_q;
  assign toggle   = tog_q;
  assign tc_pulse = tcp_q;

endmodule

// File: rtl/timer_channel.sv
`timescale 1ns/1ps
module timer_channel
  import tmr_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned STAGE_DIV [NRATE-1] = '{5, 10, 10}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_data,
  input  logic              loada_wr,
  input  logic              loadb_wr,
  input  logic [WIDTH-1:0]  load_data,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_load,
  input  logic              cmd_reset,
  input  logic              cmd_tset,
  input  logic              cmd_treset,
  input  logic              txin,
  input  logic              prev_out,
  input  logic              next_out,
  output logic [WIDTH-1:0]  count,
  output logic              running,
  output logic              toggle,
  output logic              out_pin
);

  localparam int unsigned NSTAGE = NRATE - 1;
  localparam int unsigned NSRC   = 4;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // programmable registers
  tmr_mode_t        mode_q;
  logic [WIDTH-1:0] rega_q, regb_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= tmr_mode_t'(MODE_RST);
    else if (mode_wr) mode_q <= tmr_mode_t'(mode_data);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       rega_q <= '0;
    else if (loada_wr) rega_q <= load_data;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       regb_q <= '0;
    else if (loadb_wr) regb_q <= load_data;
  end

  // internal rate enables
  logic [NSTAGE:0] tick;
  tmr_prescaler #(.NSTAGE(NSTAGE), .STAGE_DIV(STAGE_DIV)) u_presc (
    .clk  (clk),
    .rst_n(rst_ni),
    .tick (tick)
  );

  // external sources: index 1 TxIN, 2 previous, 3 next; index 0 constant
  logic [NSRC-2:0] src_raw;
  logic [NSRC-1:0] src_lvl, src_rise, src_fall;
  assign src_raw     = {next_out, prev_out, txin};
  assign src_lvl[0]  = 1'b1;
  assign src_rise[0] = 1'b0;
  assign src_fall[0] = 1'b0;

  for (genvar i = 1; i < NSRC; i++) begin : g_src
    tmr_edge_sync u_sync (
      .clk  (clk),
      .rst_n(rst_ni),
      .din  (src_raw[i-1]),
      .lvl  (src_lvl[i]),
      .rise (src_rise[i]),
      .fall (src_fall[i])
    );
  end

  // clock, gate and trigger selection
  logic cnt_tick, gate_open, cnt_en, trig_evt, trig_go;
  logic run_w, tog_w, tcp_w;

  always_comb begin
    if (mode_q.clk_src[3:2] == 2'b00)
      cnt_tick = tick[mode_q.clk_src[1:0]];
    else
      cnt_tick = edge_pick(mode_q.clk_src[1:0],
                           src_rise[mode_q.clk_src[3:2]],
                           src_fall[mode_q.clk_src[3:2]]);
    gate_open = src_lvl[mode_q.gate_src] ^ mode_q.gate_pol;
    cnt_en    = cnt_tick & gate_open;
    trig_evt  = edge_pick(mode_q.trig_edge,
                          src_rise[mode_q.trig_src],
                          src_fall[mode_q.trig_src]);
    trig_go   = trig_evt && (!run_w || mode_q.retrig);
  end

  tmr_core #(.WIDTH(WIDTH)) u_core (
    .clk       (clk),
    .rst_n     (rst_ni),
    .mode      (mode_q),
    .reg_a     (rega_q),
    .reg_b     (regb_q),
    .cnt_en    (cnt_en),
    .trig_go   (trig_go),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .cmd_load  (cmd_load),
    .cmd_reset (cmd_reset),
    .cmd_tset  (cmd_tset),
    .cmd_treset(cmd_treset),
    .count     (count),
    .running   (run_w),
    .toggle    (tog_w),
    .tc_pulse  (tcp_w)
  );

  // output conditioning
  logic out_raw;
  always_comb begin
    out_raw = mode_q.out_tgl ? tog_w : tcp_w;
    case (mode_q.out_ctl)
      OUT_DIRECT: out_pin = out_raw;
      OUT_INVERT: out_pin = ~out_raw;
      OUT_LOW:    out_pin = 1'b0;
      default:    out_pin = 1'b1;
    endcase
  end

  assign running = run_w;
  assign toggle  = tog_w;

endmodule

// File: rtl/tmr_channel_chk.sv
`timescale 1ns/1ps
module tmr_channel_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_wr,
  input logic [17:0]      mode_data,
  input logic             cmd_stop,
  input logic             cmd_load,
  input logic             cmd_reset,
  input logic             trig_go,
  input logic             cnt_en,
  input logic             up_dir,
  input logic             running,
  input logic [WIDTH-1:0] count,
  input logic             out_pin
);

  a_r6_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && mode_data[5:4] == 2'b10 |=> !out_pin);

  a_r6_forced_high: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && mode_data[5:4] == 2'b11 |=> out_pin);

  a_r7_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> !running);

  a_r7_clear_count: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> count == '0);

  a_r2_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    running && cnt_en && !up_dir && count != '0 && !cmd_reset && !cmd_load && !trig_go
    |=> count == $past(count) - WIDTH'(1));

  a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    running && cnt_en && up_dir && count != '1 && !cmd_reset && !cmd_load && !trig_go
    |=> count == $past(count) + WIDTH'(1));

  a_r11_trigger_runs: assert property (@(posedge clk) disable iff (!rst_n)
    trig_go && !cmd_stop |=> running);

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !cmd_reset && !cmd_load && !trig_go |=> $stable(count));

endmodule

bind timer_channel tmr_channel_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_ni),
  .mode_wr  (mode_wr),
  .mode_data(mode_data),
  .cmd_stop (cmd_stop),
  .cmd_load (cmd_load),
  .cmd_reset(cmd_reset),
  .trig_go  (trig_go),
  .cnt_en   (cnt_en),
  .up_dir   (mode_q.count_up),
  .running  (running),
  .count    (count),
  .out_pin  (out_pin)
);

// File: tb/timer_channel_tb_top.sv
`timescale 1ns/1ps
module timer_channel_tb_top;

  logic        clk, rst_n;
  logic        mode_wr, loada_wr, loadb_wr;
  logic [17:0] mode_data;
  logic [31:0] load_data;
  logic        cmd_start, cmd_stop, cmd_load, cmd_reset, cmd_tset, cmd_treset;
  logic        txin, prev_out, next_out;
  logic [31:0] count;
  logic        running, toggle, out_pin;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  timer_channel dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_data(mode_data),
    .loada_wr(loada_wr), .loadb_wr(loadb_wr), .load_data(load_data),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_load(cmd_load),
    .cmd_reset(cmd_reset), .cmd_tset(cmd_tset), .cmd_treset(cmd_treset),
    .txin(txin), .prev_out(prev_out), .next_out(next_out),
    .count(count), .running(running), .toggle(toggle), .out_pin(out_pin)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  // scoreboard
  typedef struct {
    logic [31:0] c;
    logic        r;
    logic        t;
    logic        o;
    string       tag;
  } exp_t;
  exp_t sb_q[$];
  exp_t mon_e;

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      mon_e = sb_q.pop_front();
      vectors++;
      if (count !== mon_e.c || running !== mon_e.r || toggle !== mon_e.t || out_pin !== mon_e.o) begin
        errors++;
        $display("FAIL %s: count=%h run=%b tog=%b out=%b, expected count=%h run=%b tog=%b out=%b",
                 mon_e.tag, count, running, toggle, out_pin, mon_e.c, mon_e.r, mon_e.t, mon_e.o);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [17:0] m);
    mode_data = m; mode_wr = 1'b1; tick(1); mode_wr = 1'b0;
  endtask

  task automatic write_a(input logic [31:0] v);
    load_data = v; loada_wr = 1'b1; tick(1); loada_wr = 1'b0;
  endtask

  task automatic write_b(input logic [31:0] v);
    load_data = v; loadb_wr = 1'b1; tick(1); loadb_wr = 1'b0;
  endtask

  // mask order {treset, tset, reset, load, stop, start}
  task automatic cmds(input logic [5:0] m);
    {cmd_treset, cmd_tset, cmd_reset, cmd_load, cmd_stop, cmd_start} = m;
    tick(1);
    {cmd_treset, cmd_tset, cmd_reset, cmd_load, cmd_stop, cmd_start} = '0;
  endtask

  task automatic wig(input int which, input int n);
    for (int k = 0; k < n; k++) begin
      case (which)
        0:       txin     = ~txin;
        1:       prev_out = ~prev_out;
        default: next_out = ~next_out;
      endcase
      tick(4);
    end
  endtask

  // reference sequence from the requirements, core clock as count clock
  logic [31:0] m_c;
  logic        m_t, m_run, m_tcl;

  task automatic run_model(input string tag, input int n, input bit up, input bit rep,
                           input bit alt, input bit otgl, input logic [1:0] octl,
                           input logic [31:0] a, input logic [31:0] b);
    exp_t e;
    logic raw, tc;
    m_run = 1'b1; m_tcl = 1'b0;
    for (int k = 0; k < n; k++) begin
      raw = otgl ? m_t : m_tcl;
      e.c = m_c; e.r = m_run; e.t = m_t; e.tag = tag;
      case (octl)
        2'b00:   e.o = raw;
        2'b01:   e.o = ~raw;
        2'b10:   e.o = 1'b0;
        default: e.o = 1'b1;
      endcase
      sb_q.push_back(e);
      tc = m_run && (up ? (m_c == 32'hFFFF_FFFF) : (m_c == 32'h0));
      if (tc) begin
        m_t = ~m_t;
        m_c = (alt && !m_t) ? b : a;
        if (!rep) m_run = 1'b0;
      end else if (m_run) begin
        m_c = up ? m_c + 1 : m_c - 1;
      end
      m_tcl = tc;
    end
  endtask

  logic [31:0] c1;

  initial begin
    rst_n = 1'b0;
    {mode_wr, loada_wr, loadb_wr} = '0;
    mode_data = '0; load_data = '0;
    {cmd_treset, cmd_tset, cmd_reset, cmd_load, cmd_stop, cmd_start} = '0;
    txin = 1'b0; prev_out = 1'b0; next_out = 1'b0;
    #21 rst_n = 1'b1;
    tick(4);

    // R1 reset state
    chk("R1 count", count, 32'h0);
    chk("R1 running", {31'h0, running}, 32'h0);
    chk("R1 toggle", {31'h0, toggle}, 32'h0);
    chk("R1 out forced low", {31'h0, out_pin}, 32'h0);

    // R2 R3 R5 single-shot down count, pulse output
    set_mode(18'h00000);
    write_a(32'd5);
    cmds(6'b100100);
    cmds(6'b000001);
    m_c = 32'd5; m_t = 1'b0;
    run_model("R3 single shot down", 9, 0, 0, 0, 0, 2'b00, 32'd5, 32'd0);
    tick(9);

    // R4 R5 alternate reload PWM on the toggle
    set_mode(18'h0000E);
    write_a(32'd2);
    write_b(32'd1);
    cmds(6'b010000);
    cmds(6'b000100);
    chk("R4 load takes A when toggle set", count, 32'd2);
    cmds(6'b000001);
    m_c = 32'd2; m_t = 1'b1;
    run_model("R4 alternate reload pwm", 14, 0, 1, 1, 1, 2'b00, 32'd2, 32'd1);
    tick(14);
    cmds(6'b000010);

    // R2 R6 up count wrap, inverted pulse output
    set_mode(18'h00013);
    write_a(32'hFFFF_FFFD);
    cmds(6'b100100);
    cmds(6'b000001);
    m_c = 32'hFFFF_FFFD; m_t = 1'b0;
    run_model("R2 up wrap inverted", 8, 1, 1, 0, 0, 2'b01, 32'hFFFF_FFFD, 32'd1);
    tick(8);
    cmds(6'b000010);

    // R7 command priorities
    set_mode(18'h00008);
    write_a(32'd100);
    cmds(6'b001100);
    chk("R7 clear beats load", count, 32'h0);
    cmds(6'b000011);
    chk("R7 stop beats start", {31'h0, running}, 32'h0);
    cmds(6'b110000);
    chk("R7 toggle clear beats set", {31'h0, toggle}, 32'h0);
    chk("R5 toggle output low", {31'h0, out_pin}, 32'h0);
    cmds(6'b010000);
    chk("R5 toggle output high", {31'h0, out_pin}, 32'h1);
    cmds(6'b000100);
    chk("R7 load from A", count, 32'd100);

    // R6 output drive
    set_mode(18'h00028);
    chk("R6 forced low", {31'h0, out_pin}, 32'h0);
    set_mode(18'h00018);
    chk("R6 inverted", {31'h0, out_pin}, 32'h0);
    set_mode(18'h00038);
    chk("R6 forced high", {31'h0, out_pin}, 32'h1);

    // R8 internal rates
    set_mode(18'h04000);
    write_a(32'd1000);
    cmds(6'b000101);
    c1 = count; tick(50);
    chk("R8 rate 1/5", c1 - count, 32'd10);
    set_mode(18'h08000);
    c1 = count; tick(500);
    chk("R8 rate 1/50", c1 - count, 32'd10);
    set_mode(18'h0C000);
    c1 = count; tick(500);
    chk("R8 rate 1/500", c1 - count, 32'd1);

    // R9 external clock edges
    set_mode(18'h14000);
    cmds(6'b000101);
    tick(4);
    c1 = count; wig(0, 6);
    chk("R9 txin rising", c1 - count, 32'd3);
    set_mode(18'h1C000);
    c1 = count; wig(0, 6);
    chk("R9 txin both edges", c1 - count, 32'd6);
    set_mode(18'h28000);
    c1 = count; wig(1, 6);
    chk("R9 previous falling", c1 - count, 32'd3);
    set_mode(18'h3C000);
    c1 = count; wig(2, 4);
    chk("R9 next both edges", c1 - count, 32'd4);
    set_mode(18'h10000);
    c1 = count; wig(0, 4);
    chk("R9 reserved 0100", c1 - count, 32'd0);
    set_mode(18'h20000);
    c1 = count; wig(1, 4);
    chk("R9 reserved 1000", c1 - count, 32'd0);
    set_mode(18'h30000);
    c1 = count; wig(2, 4);
    chk("R9 reserved 1100", c1 - count, 32'd0);

    // R10 gate
    txin = 1'b0;
    set_mode(18'h00800);
    tick(4);
    cmds(6'b000101);
    tick(5);
    chk("R10 low gate blocks", count, 32'd1000);
    txin = 1'b1;
    tick(10);
    chk("R10 high gate counts", count, 32'd992);
    set_mode(18'h02800);
    chk("R10 mode write cycle counts", count, 32'd991);
    tick(5);
    chk("R10 inverted polarity blocks high", count, 32'd991);
    txin = 1'b0;

    // R11 R12 trigger and retrigger from the previous channel, rising edge
    cmds(6'b000010);
    set_mode(18'h00180);
    write_a(32'd50);
    tick(3);
    prev_out = 1'b1;
    tick(2);
    chk("R11 trigger latency", {31'h0, running}, 32'h0);
    tick(1);
    chk("R11 trigger loads", count, 32'd50);
    chk("R11 trigger starts", {31'h0, running}, 32'h1);
    tick(5);
    prev_out = 1'b0;
    tick(2);
    prev_out = 1'b1;
    tick(3);
    chk("R12 no retrigger while running", count, 32'd40);
    set_mode(18'h00580);
    chk("R12 count before retrigger", count, 32'd39);
    prev_out = 1'b0;
    tick(2);
    prev_out = 1'b1;
    tick(3);
    chk("R12 retrigger reloads", count, 32'd50);
    cmds(6'b000010);
    set_mode(18'h00080);
    prev_out = 1'b0;
    tick(3);
    prev_out = 1'b1;
    tick(4);
    chk("R11 edge select none", {31'h0, running}, 32'h0);

    tick(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run incomplete, expected completion before timeout");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule